// File: doc/BRIEF.md
# Counting-Enable Interrupt Source Aggregator

This block holds the state of a fixed set of interrupt sources and combines them into one interrupt request for a processor. Each source has a level request input and an enable counter. Each source also has a required count, fixed by parameter. The required count is the number of separate mask bits, priority fields and group memberships that must all allow the source. A register unit elsewhere decodes software writes and sends one strobe per changed field: "one more enable" or "one fewer enable" for a given source index.

A source is pending only while its request is held and its enable counter has reached its required count. A running tally of pending sources is kept. The tally moves by the number of pending bits that rose minus the number that fell. The processor request line is high while the tally is non-zero. A selector reports the vector of the lowest-numbered pending source with a valid flag. It reports nothing while the processor's interrupt mask is at its all-ones level. Vectors are parameter values that are loaded into each source slot at reset.

Top module: `irq_src_agg`

## Requirements
- R1: The internal asserted state of a source follows its request input with one cycle of latency. It changes only when the input differs from it, so a level that is held has no further effect.
- R2: Bit i of `pend_bits` is 1 exactly when source i is asserted and its enable counter equals its required count. A source whose required count is 0 is pending whenever it is asserted.
- R3: An enable strobe (`en_stb`=1, `en_up`=1 for an increment, 0 for a decrement) changes only the counter of source `en_idx`. The counter saturates: an increment at the required count is ignored, and a decrement at 0 is ignored. An index at or above the source count changes nothing.
- R4: `pend_cnt` equals the number of 1 bits that `pend_bits` held one cycle earlier. It is updated by adding the bits that rose and subtracting the bits that fell.
- R5: `cpu_irq` is 1 exactly when `pend_cnt` is non-zero. It rises on a move of the count from 0 and falls when the count returns to 0.
- R6: While at least one source is pending and `imask` is not 4'hF, `vec_valid` is 1 and `vec_out` is the vector of the lowest-indexed pending source. Otherwise `vec_valid` is 0 and `vec_out` is 0.
- R7: While `imask` equals 4'hF, `vec_valid` is 0, whatever sources are pending.
- R8: After a synchronous active-low reset, every asserted state, enable counter, `pend_bits`, `pend_cnt`, `cpu_irq` and `vec_valid` is 0.
- R9: The vector of source i is VEC_BASE + i*VEC_STEP, truncated to VEC_W bits. It is loaded into the source slot during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | N_SRC | Level request per source |
| en_stb | input | 1 | Enable-adjust strobe, one cycle |
| en_up | input | 1 | 1 adds one enable, 0 removes one |
| en_idx | input | IDX_W | Source index of the strobe |
| imask | input | 4 | Processor interrupt mask level |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | `vec_out` holds a vector |
| vec_out | output | VEC_W | Vector of the lowest pending source |
| pend_bits | output | N_SRC | Pending state per source |
| pend_cnt | output | CNT_PW | Running count of pending sources |

## Verification
The hardest case to reach is a counter sitting at a saturation limit. Such a counter looks the same at the ports as one that wrapped, until a later strobe moves it back the wrong way. The bench drives long runs of increments past the required count, then applies a single decrement. It also drives decrements at zero, then a single increment. A pseudo-random sweep then mixes request levels, strobes and mask levels on every source. After each step the bench compares all outputs with an arithmetic model of the counters.

// File: rtl/irq_src_agg_pkg.sv
// Package: shared constants and types of the interrupt source aggregator.
package irq_src_agg_pkg;
    localparam int          IMASK_W   = 4;
    localparam logic [3:0]  IMASK_ALL = 4'hF;

    typedef enum logic {
        EN_DOWN = 1'b0,
        EN_UP   = 1'b1
    } en_dir_e;
endpackage

// File: rtl/irq_src_slot.sv
// Module: one interrupt source slot.
// Holds the asserted state, a saturating enable counter and the vector of
// one source. Assumes at most one enable strobe per cycle (hit qualifies it).
module irq_src_slot
    import irq_src_agg_pkg::*;
#(
    parameter int               CNT_W = 3,
    parameter int               VEC_W = 12,
    parameter logic [CNT_W-1:0] REQ   = '0,
    parameter logic [VEC_W-1:0] VEC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_lvl,
    input  logic             hit,
    input  logic             up,
    output logic             asrt,
    output logic [CNT_W-1:0] en_cnt,
    output logic             pend,
    output logic [VEC_W-1:0] vec
);
    // Track the request level, writing only on a change of level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            asrt <= 1'b0;
        else if (req_lvl != asrt)
            asrt <= req_lvl;
    end

    // Saturating enable counter between 0 and REQ.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_cnt <= '0;
        else if (hit) begin
            if (en_dir_e'(up) == EN_UP && en_cnt != REQ)
                en_cnt <= en_cnt + 1'b1;
            else if (en_dir_e'(up) == EN_DOWN && en_cnt != '0)
                en_cnt <= en_cnt - 1'b1;
        end
    end

    // Vector register, loaded from the parameter during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec <= VEC;
    end

    // Pending when asserted and every enable is present.
    always_comb pend = asrt && (en_cnt == REQ);
endmodule

// File: rtl/irq_pend_tally.sv
// Module: running pending tally and processor request line.
// Counts rising pending bits minus falling pending bits against the previous
// cycle. Assumes reset clears every source so the tally starts in step.
module irq_pend_tally #(
    parameter int N_SRC  = 8,
    parameter int CNT_PW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  pend,
    output logic [CNT_PW-1:0] pend_cnt,
    output logic              cpu_irq
);
    logic [N_SRC-1:0]  pend_prev;
    logic [CNT_PW-1:0] rises, falls, cnt_nxt;

    // Count pending edges since last cycle.
    always_comb begin
        rises   = CNT_PW'($countones(pend & ~pend_prev));
        falls   = CNT_PW'($countones(pend_prev & ~pend));
        cnt_nxt = pend_cnt + rises - falls;
    end

    // Update tally, edge history and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_prev <= '0;
            pend_cnt  <= '0;
            cpu_irq   <= 1'b0;
        end else begin
            pend_prev <= pend;
            pend_cnt  <= cnt_nxt;
            cpu_irq   <= (cnt_nxt != '0);
        end
    end
endmodule

// File: rtl/irq_vec_pick.sv
// Module: lowest-index pending vector selector.
// Purely combinational; suppressed while the mask is at its all-ones level.
module irq_vec_pick
    import irq_src_agg_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 12
) (
    input  logic [N_SRC-1:0]       pend,
    input  logic [N_SRC*VEC_W-1:0] vecs,
    input  logic [IMASK_W-1:0]     imask,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_out
);
    logic             any;
    logic [VEC_W-1:0] sel;

    // Scan downward so the lowest pending index is the last to win.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                sel = vecs[i*VEC_W +: VEC_W];
            end
        end
    end

    // Gate by the mask level.
    always_comb begin
        vec_valid = any && (imask != IMASK_ALL);
        vec_out   = vec_valid ? sel : '0;
    end
endmodule

// File: rtl/irq_src_agg.sv
// Module: counting-enable interrupt source aggregator (top).
// Instantiates one slot per source, the pending tally and the vector
// selector. Assumes the register unit sends at most one enable strobe per
// cycle; strobes to an index outside the source range are dropped.
module irq_src_agg
    import irq_src_agg_pkg::*;
#(
    parameter int                     N_SRC    = 8,
    parameter int                     CNT_W    = 3,
    parameter int                     VEC_W    = 12,
    parameter logic [N_SRC*CNT_W-1:0] REQ_CNTS = {3'd2, 3'd1, 3'd0, 3'd4,
                                                  3'd3, 3'd2, 3'd1, 3'd0},
    parameter logic [VEC_W-1:0]       VEC_BASE = 12'h400,
    parameter logic [VEC_W-1:0]       VEC_STEP = 12'h020,
    localparam int                    IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int                    CNT_PW   = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              en_stb,
    input  logic              en_up,
    input  logic [IDX_W-1:0]  en_idx,
    input  logic [IMASK_W-1:0] imask,
    output logic              cpu_irq,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic [N_SRC-1:0]  pend_bits,
    output logic [CNT_PW-1:0] pend_cnt
);
    logic [N_SRC-1:0]       asrt_vec;
    logic [N_SRC*CNT_W-1:0] en_flat;
    logic [N_SRC*VEC_W-1:0] vec_flat;

    // One slot per source, each with its own required count and vector.
    for (genvar i = 0; i < N_SRC; i++) begin : g_slot
        logic hit;
        // Decode the strobe for this slot.
        always_comb hit = en_stb && (en_idx == IDX_W'(i));

        irq_src_slot #(
            .CNT_W (CNT_W),
            .VEC_W (VEC_W),
            .REQ   (REQ_CNTS[i*CNT_W +: CNT_W]),
            .VEC   (VEC_W'(VEC_BASE + VEC_W'(i) * VEC_STEP))
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_lvl (src_req[i]),
            .hit     (hit),
            .up      (en_up),
            .asrt    (asrt_vec[i]),
            .en_cnt  (en_flat[i*CNT_W +: CNT_W]),
            .pend    (pend_bits[i]),
            .vec     (vec_flat[i*VEC_W +: VEC_W])
        );
    end

    irq_pend_tally #(
        .N_SRC  (N_SRC),
        .CNT_PW (CNT_PW)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_bits),
        .pend_cnt (pend_cnt),
        .cpu_irq  (cpu_irq)
    );

    irq_vec_pick #(
        .N_SRC (N_SRC),
        .VEC_W (VEC_W)
    ) u_pick (
        .pend      (pend_bits),
        .vecs      (vec_flat),
        .imask     (imask),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );
endmodule

// File: rtl/irq_src_agg_chk.sv
// Module: assertion checker bound to the aggregator top.
// A short warm-up counter keeps $past away from pre-reset values.
module irq_src_agg_chk #(
    parameter int                     N_SRC    = 8,
    parameter int                     CNT_W    = 3,
    parameter logic [N_SRC*CNT_W-1:0] REQ_CNTS = '0,
    parameter int                     CNT_PW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_req,
    input logic [3:0]        imask,
    input logic [N_SRC-1:0]  asrt_vec,
    input logic [N_SRC*CNT_W-1:0] en_flat,
    input logic [N_SRC-1:0]  pend_bits,
    input logic [CNT_PW-1:0] pend_cnt,
    input logic              cpu_irq,
    input logic              vec_valid
);
    logic [1:0] warm;
    logic       ready;

    // Count cycles out of reset, stopping at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= 2'd0;
        else if (warm != 2'd2)
            warm <= warm + 2'd1;
    end
    always_comb ready = (warm == 2'd2);

    p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        asrt_vec == $past(src_req));

    p_pend_subset_r2: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        (pend_bits & ~asrt_vec) == '0);

    p_tally_r4: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        pend_cnt == CNT_PW'($countones($past(pend_bits))));

    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        cpu_irq == (pend_cnt != '0));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        $rose(cpu_irq) |-> $past(pend_cnt) == '0);

    p_valid_src_r6: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        vec_valid |-> pend_bits != '0);

    p_valid_any_r6: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        (pend_bits != '0 && imask != 4'hF) |-> vec_valid);

    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n || !ready)
        imask == 4'hF |-> !vec_valid);

    for (genvar i = 0; i < N_SRC; i++) begin : g_cnt
        p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            en_flat[i*CNT_W +: CNT_W] <= REQ_CNTS[i*CNT_W +: CNT_W]);
    end
endmodule

bind irq_src_agg irq_src_agg_chk #(
    .N_SRC    (N_SRC),
    .CNT_W    (CNT_W),
    .REQ_CNTS (REQ_CNTS),
    .CNT_PW   (CNT_PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .imask     (imask),
    .asrt_vec  (asrt_vec),
    .en_flat   (en_flat),
    .pend_bits (pend_bits),
    .pend_cnt  (pend_cnt),
    .cpu_irq   (cpu_irq),
    .vec_valid (vec_valid)
);

// File: tb/irq_src_agg_bench.sv
module irq_src_agg_bench;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] REQS = {3'd2, 3'd1, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [11:0] VB = 12'h400;
    localparam logic [11:0] VS = 12'h020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic        en_stb = 1'b0;
    logic        en_up = 1'b0;
    logic [2:0]  en_idx = '0;
    logic [3:0]  imask = '0;
    logic        cpu_irq, vec_valid;
    logic [11:0] vec_out;
    logic [N-1:0] pend_bits;
    logic [3:0]  pend_cnt;

    int total = 0;
    int bad = 0;
    int en_m [N];
    logic [N-1:0] req_m;
    logic [3:0]  mask_m;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_src_agg u_irq_src_agg (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_stb(en_stb),
        .en_up(en_up), .en_idx(en_idx), .imask(imask), .cpu_irq(cpu_irq),
        .vec_valid(vec_valid), .vec_out(vec_out), .pend_bits(pend_bits),
        .pend_cnt(pend_cnt)
    );

    function automatic int req_of(input int i);
        return int'(REQS[i*3 +: 3]);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the arithmetic model.
    task automatic chk_all(input string tag);
        logic [N-1:0] ep;
        int cnt;
        logic ev;
        logic [11:0] evec;
        ep = '0;
        for (int i = 0; i < N; i++)
            ep[i] = req_m[i] && (en_m[i] == req_of(i));
        cnt = $countones(ep);
        ev = 1'b0;
        evec = '0;
        if (mask_m != 4'hF) begin
            for (int i = N - 1; i >= 0; i--)
                if (ep[i]) begin
                    ev = 1'b1;
                    evec = 12'(VB + 12'(i) * VS);
                end
        end
        chk({tag, " R2"}, "pend_bits", 32'(pend_bits), 32'(ep));
        chk({tag, " R4"}, "pend_cnt", 32'(pend_cnt), 32'(cnt));
        chk({tag, " R5"}, "cpu_irq", 32'(cpu_irq), 32'(cnt != 0));
        chk({tag, " R6"}, "vec_valid", 32'(vec_valid), 32'(ev));
        chk({tag, " R9"}, "vec_out", 32'(vec_out), 32'(evec));
    endtask

    // Drive one step, hold the strobe one cycle, wait for the tally.
    task automatic step(input logic [N-1:0] r, input logic s, input logic u,
                        input logic [2:0] ix, input logic [3:0] m);
        @(negedge clk);
        src_req = r; en_stb = s; en_up = u; en_idx = ix; imask = m;
        @(negedge clk);
        en_stb = 1'b0;
        req_m = r;
        mask_m = m;
        if (s) begin
            if (u && en_m[ix] != req_of(int'(ix))) en_m[ix]++;
            else if (!u && en_m[ix] != 0) en_m[ix]--;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < N; i++) en_m[i] = 0;
        req_m = '0;
        mask_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8", "pend_bits", 32'(pend_bits), 0);
        chk("R8", "pend_cnt", 32'(pend_cnt), 0);
        chk("R8", "cpu_irq", 32'(cpu_irq), 0);
        chk("R8", "vec_valid", 32'(vec_valid), 0);

        // R1: request alone on source 0 (required count 0) pends; held level stays.
        step(8'h01, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_all("R1 rise");
        step(8'h01, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_all("R1 held");
        step(8'h00, 1'b0, 1'b0, 3'd0, 4'h0);
        chk_all("R1 fall");

        // R3: increments past saturation on source 3, then one decrement.
        for (int k = 0; k < 6; k++) step(8'h08, 1'b1, 1'b1, 3'd3, 4'h0);
        chk_all("R3 sat high");
        chk("R3", "pend3 saturated", 32'(pend_bits[3]), 1);
        step(8'h08, 1'b1, 1'b0, 3'd3, 4'h0);
        chk("R3", "pend3 after one dec", 32'(pend_bits[3]), 0);
        chk_all("R3 dec");

        // R3: decrements at zero on source 1, then one increment.
        for (int k = 0; k < 3; k++) step(8'h0A, 1'b1, 1'b0, 3'd1, 4'h0);
        step(8'h0A, 1'b1, 1'b1, 3'd1, 4'h0);
        chk("R3", "pend1 after floor", 32'(pend_bits[1]), 1);
        chk_all("R3 floor");

        // R7: full mask hides the vector while pending stays.
        step(8'h0A, 1'b0, 1'b0, 3'd0, 4'hF);
        chk("R7", "vec_valid masked", 32'(vec_valid), 0);
        chk_all("R7 masked");
        step(8'h0A, 1'b0, 1'b0, 3'd0, 4'hE);
        chk_all("R7 mask E");

        // R6: lowest index wins when several pend.
        step(8'h0B, 1'b0, 1'b0, 3'd0, 4'h3);
        chk("R6", "lowest vector", 32'(vec_out), 32'(VB));
        chk_all("R6 multi");

        // Pseudo-random sweep across levels, strobes and masks.
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            step(lf[7:0], lf[8], lf[9] | lf[10], lf[13:11],
                 (lf[15:14] == 2'b11) ? 4'hF : {2'b00, lf[1:0]});
            chk_all("sweep R1 R3 R6");
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule